// File: doc/BRIEF.md
# Saturating Double-and-Accumulate Unit

This block is a 32-bit signed arithmetic unit. It first doubles the second operand and clamps that product to the signed range. It then adds the clamped product to the first operand, or subtracts it from the first operand, and clamps the result a second time. Both clamping stages feed one sticky overflow bit. That bit stays high until software-side logic pulses a clear input or the block is reset.

A datapath drives an operation by holding `in_valid` high for one cycle with both operands and the mode select. The result is registered, so it appears on `res_out` one clock later, with `res_valid` high for that cycle. When `in_valid` is low, the result register keeps its value. In that case the sticky bit changes only through the clear input.

Top module: `sat_dbl_acc`

## Requirements
- R1: While synchronous reset is high, the next clock edge sets `res_out` to 0, `q_flag` to 0 and `res_valid` to 0.
- R2: The doubling stage clips when bits 31 and 30 of `op_b` differ. A positive operand (bit 31 = 0) clips to 0x7FFFFFFF and a negative operand clips to 0x80000000. Otherwise the doubled value is `op_b` shifted left by one.
- R3: With `sub_sel` = 0, the result is the first operand plus the doubled value.
- R4: With `sub_sel` = 1, the result is the first operand minus the doubled value.
- R5: The sum or difference is clamped to the range -2147483648 to 2147483647, giving 0x80000000 or 0x7FFFFFFF at the limits.
- R6: An accepted operation (`in_valid` = 1) in which either stage clips sets `q_flag` to 1 on the next edge. Without an accepted operation, `q_flag` never rises.
- R7: `q_flag` stays at 1 through later operations that do not clip, for as long as `flag_clr` is low.
- R8: `flag_clr` high, in a cycle without a clipping operation, drives `q_flag` to 0 on the next edge.
- R9: When `flag_clr` arrives in the same cycle as a clipping operation, `q_flag` ends at 1.
- R10: When `in_valid` is low, `res_out` keeps its value.
- R11: `res_valid` is high exactly in the cycle after an accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts the operands and mode this cycle |
| sub_sel | input | 1 | 0: accumulate by adding, 1: by subtracting |
| flag_clr | input | 1 | Clears the sticky overflow bit |
| op_a | input | 32 | First operand (signed) |
| op_b | input | 32 | Operand to be doubled (signed) |
| res_out | output | 32 | Registered saturated result |
| res_valid | output | 1 | Result was updated on the last edge |
| q_flag | output | 1 | Sticky saturation indicator |

## Verification
The assertions assume that reset is held high over the first clock edge, and that every input has a known value at each rising edge. The sign-based checks also take `op_a` and `op_b` as two's-complement values. The bench holds reset for several cycles before releasing it. It changes inputs only on falling edges and returns `in_valid`, `sub_sel` and `flag_clr` to 0 between operations, so every check sees a defined previous state.

// File: rtl/sda_pkg.sv
package sda_pkg;
    // Default datapath width of the unit
    localparam int SDA_W = 32;

    // Accumulate direction selected per operation
    typedef enum logic {
        ACC_ADD = 1'b0,
        ACC_SUB = 1'b1
    } acc_mode_e;

    // Control bundle captured with each operation
    typedef struct packed {
        logic      valid;
        logic      clr;
        acc_mode_e mode;
    } op_ctl_t;
endpackage

// File: rtl/sda_doubler.sv
module sda_doubler
    import sda_pkg::*;
#(
    parameter int W = SDA_W
) (
    input  logic [W-1:0] b_in,
    output logic [W-1:0] dbl_out,
    output logic         dbl_clip
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    // A left shift loses the sign whenever the two top bits disagree
    always_comb begin
        dbl_clip = b_in[W-1] ^ b_in[W-2];
        if (!dbl_clip)
            dbl_out = {b_in[W-2:0], 1'b0};
        else if (b_in[W-1])
            dbl_out = NEG_LIM;
        else
            dbl_out = POS_LIM;
    end
endmodule

// File: rtl/sda_accum.sv
module sda_accum
    import sda_pkg::*;
#(
    parameter int W = SDA_W
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] d_in,
    input  acc_mode_e    mode,
    output logic [W-1:0] acc_out,
    output logic         acc_clip
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ext_a;
    logic [W:0] ext_d;
    logic [W:0] wide;

    // One guard bit: overflow shows as guard and sign bits disagreeing
    always_comb begin
        ext_a = {a_in[W-1], a_in};
        ext_d = {d_in[W-1], d_in};
        if (mode == ACC_SUB)
            wide = ext_a - ext_d;
        else
            wide = ext_a + ext_d;
        acc_clip = wide[W] ^ wide[W-1];
        if (!acc_clip)
            acc_out = wide[W-1:0];
        else if (wide[W])
            acc_out = NEG_LIM;
        else
            acc_out = POS_LIM;
    end
endmodule

// File: rtl/sda_qflag.sv
module sda_qflag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic q
);
    // Set dominates clear so a clip in the clearing cycle is not lost
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (set_req)
            q <= 1'b1;
        else if (clr_req)
            q <= 1'b0;
    end
endmodule

// File: rtl/sat_dbl_acc.sv
module sat_dbl_acc
    import sda_pkg::*;
#(
    parameter int W = SDA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         sub_sel,
    input  logic         flag_clr,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] res_out,
    output logic         res_valid,
    output logic         q_flag
);
    op_ctl_t      ctl;
    logic [W-1:0] dbl_val;
    logic         dbl_clip;
    logic [W-1:0] acc_val;
    logic         acc_clip;

    always_comb begin
        ctl.valid = in_valid;
        ctl.clr   = flag_clr;
        ctl.mode  = sub_sel ? ACC_SUB : ACC_ADD;
    end

    sda_doubler #(.W(W)) u_dbl (
        .b_in     (op_b),
        .dbl_out  (dbl_val),
        .dbl_clip (dbl_clip)
    );

    sda_accum #(.W(W)) u_acc (
        .a_in     (op_a),
        .d_in     (dbl_val),
        .mode     (ctl.mode),
        .acc_out  (acc_val),
        .acc_clip (acc_clip)
    );

    sda_qflag u_q (
        .clk     (clk),
        .rst     (rst),
        .set_req (ctl.valid & (dbl_clip | acc_clip)),
        .clr_req (ctl.clr),
        .q       (q_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out   <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= ctl.valid;
            if (ctl.valid)
                res_out <= acc_val;
        end
    end
endmodule

// File: rtl/sda_checker.sv
module sda_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         sub_sel,
    input logic         flag_clr,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] res_out,
    input logic         res_valid,
    input logic         q_flag
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (res_out == '0 && !q_flag && !res_valid)); // R1

    AST_DBL_POS_CLIP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sub_sel && op_a == '0 && !op_b[W-1] && op_b[W-2])
        |=> (res_out == POS_LIM)); // R2

    AST_ADD_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sub_sel && !op_a[W-1] && !op_b[W-1])
        |=> !res_out[W-1]); // R3

    AST_SUB_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sub_sel && !op_a[W-1] && op_b[W-1])
        |=> !res_out[W-1]); // R4

    AST_CLIP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_b[W-1] != op_b[W-2]) |=> q_flag); // R6

    AST_NO_SPONTANEOUS_Q: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !q_flag) |=> !q_flag); // R6

    AST_Q_STICKY: assert property (@(posedge clk) disable iff (rst)
        (q_flag && !flag_clr) |=> q_flag); // R7

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !in_valid) |=> !q_flag); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_out)); // R10

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid); // R11

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid); // R11
endmodule

bind sat_dbl_acc sda_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sub_sel   (sub_sel),
    .flag_clr  (flag_clr),
    .op_a      (op_a),
    .op_b      (op_b),
    .res_out   (res_out),
    .res_valid (res_valid),
    .q_flag    (q_flag)
);

// File: tb/sim_sat_dbl_acc.sv
module sim_sat_dbl_acc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        sub_sel = 1'b0;
    logic        flag_clr = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] res_out;
    logic        res_valid;
    logic        q_flag;

    int checks = 0;
    int errors = 0;
    logic exp_q = 1'b0;

    always #4 clk = ~clk;

    sat_dbl_acc u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sub_sel(sub_sel),
        .flag_clr(flag_clr), .op_a(op_a), .op_b(op_b),
        .res_out(res_out), .res_valid(res_valid), .q_flag(q_flag)
    );

    // Reference arithmetic in 64-bit signed integers
    function automatic logic [31:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                           input logic sub, output logic clipped);
        longint da;
        longint r;
        clipped = 1'b0;
        da = 2 * longint'($signed(b));
        if (da > 64'sd2147483647) begin da = 64'sd2147483647; clipped = 1'b1; end
        if (da < -64'sd2147483648) begin da = -64'sd2147483648; clipped = 1'b1; end
        r = sub ? longint'($signed(a)) - da : longint'($signed(a)) + da;
        if (r > 64'sd2147483647) begin r = 64'sd2147483647; clipped = 1'b1; end
        if (r < -64'sd2147483648) begin r = -64'sd2147483648; clipped = 1'b1; end
        return r[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Applies one operation and checks result, valid pulse and flag
    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic sub, input logic clr);
        logic clipped;
        logic [31:0] exp_r;
        exp_r = ref_op(a, b, sub, clipped);
        if (clipped) exp_q = 1'b1;
        else if (clr) exp_q = 1'b0;
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = sub; flag_clr = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0; sub_sel = 1'b0;
        check({tag, " result"}, res_out, exp_r);
        check("R11 valid pulse", {31'd0, res_valid}, 32'd1);
        check({tag, " flag"}, {31'd0, q_flag}, {31'd0, exp_q});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 result", res_out, 32'd0);
        check("R1 flag", {31'd0, q_flag}, 32'd0);
        check("R1 valid", {31'd0, res_valid}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_add;
        run_op("R3 add small", 32'd100, 32'd7, 1'b0, 1'b0);
        run_op("R3 add negative", 32'hFFFF_FF00, 32'hFFFF_FFF0, 1'b0, 1'b0);
        run_op("R3 add mixed", 32'h0000_1000, 32'hFFFF_F000, 1'b0, 1'b0);
    endtask

    task automatic t_sub;
        run_op("R4 sub small", 32'd100, 32'd7, 1'b1, 1'b0);
        run_op("R4 sub negative", 32'hFFFF_FF00, 32'hFFFF_FF80, 1'b1, 1'b0);
    endtask

    task automatic t_double_edges;
        run_op("R2 max no clip", 32'd0, 32'h3FFF_FFFF, 1'b0, 1'b0);
        run_op("R2 min no clip", 32'd0, 32'hC000_0000, 1'b0, 1'b0);
        run_op("R2 R6 pos clip", 32'd0, 32'h4000_0000, 1'b0, 1'b0);
        run_op("R7 sticky after clip", 32'd1, 32'd1, 1'b0, 1'b0);
        run_op("R8 clear", 32'd2, 32'd2, 1'b0, 1'b1);
        run_op("R2 R6 neg clip", 32'd0, 32'hBFFF_FFFF, 1'b0, 1'b0);
        run_op("R8 clear again", 32'd0, 32'd0, 1'b1, 1'b1);
    endtask

    task automatic t_final_clip;
        run_op("R5 R6 top clip", 32'h7FFF_FFF0, 32'h0000_0010, 1'b0, 1'b0);
        run_op("R8 clear", 32'd0, 32'd0, 1'b0, 1'b1);
        run_op("R5 R6 bottom clip", 32'h8000_0000, 32'd1, 1'b1, 1'b0);
        run_op("R5 exact limit", 32'h7FFF_FFFE, 32'd0, 1'b0, 1'b1);
        run_op("R5 sub top clip", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    endtask

    task automatic t_clear_collide;
        run_op("R9 clear with clip", 32'h7FFF_0000, 32'h4000_0000, 1'b0, 1'b1);
        run_op("R7 still set", 32'd5, 32'd3, 1'b1, 1'b0);
    endtask

    task automatic t_idle;
        logic [31:0] held;
        held = res_out;
        @(negedge clk);
        op_a = 32'h1234_5678; op_b = 32'h0000_0001; sub_sel = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 result held", res_out, held);
        check("R11 no valid while idle", {31'd0, res_valid}, 32'd0);
        check("R6 flag unchanged while idle", {31'd0, q_flag}, {31'd0, exp_q});
        flag_clr = 1'b1;
        exp_q = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8 idle clear", {31'd0, q_flag}, 32'd0);
        check("R10 result held on clear", res_out, held);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_double_edges();
        t_final_clip();
        t_clear_collide();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule